// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

This block is one channel of a down-counting timer with a pulse-width output and a zero-count interrupt. Software writes a period value and a compare value into two buffer registers, and a few control bits (start, manual update, auto-reload, output invert) into a control register, all through a one-cycle write strobe with a select code. The active counter and the active compare register take new values only on a manual update or an automatic reload at zero. Buffer writes made while the channel runs therefore take effect on a period boundary, and the output never shows a partly updated period or duty cycle.

Counting advances on a single-cycle tick enable supplied by an external clock-division stage. On a tick at count zero the channel pulses its interrupt. It then either reloads from the buffers or, with auto-reload off, parks at zero and clears its own start bit. Clearing the start bit by software freezes the count where it stands and does not reload it. The output is low while the count is above the compare value and high once the count has reached it. The invert bit reverses this pattern.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset the count and the compare register are zero, `irq_o` and `run_o` are low, and `pwm_o` is high. The output is high because a count of 0 is not above a compare value of 0, and invert is off.
- R2: While running with manual update clear, each tick lowers a nonzero count by one. Without a tick the count holds.
- R3: A tick while running at count zero, with manual update clear, makes `irq_o` high for exactly the following clock cycle.
- R4: While the manual-update bit is set, the counter and compare register reload from the buffers on every clock and no counting takes place.
- R5: At a zero event with auto-reload set, the counter takes the period buffer and the compare register takes the compare buffer.
- R6: At a zero event with auto-reload clear, the count stays at zero and the start bit clears, so `run_o` falls. A control write in that same cycle takes priority over this clearing.
- R7: Clearing the start bit freezes the count at its present value, with no reload.
- R8: Buffer writes change neither the active count nor the active compare value until the next reload or manual update.
- R9: `pwm_o` is low while count > compare and high while count <= compare. With the invert bit set, both levels are reversed.
- R10: Write decoding: `wr_sel_i` 0 selects the period buffer, 1 the compare buffer, and 2 the control register. The control bits are [0] start, [1] manual update, [2] auto-reload and [3] invert. Select code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Single-cycle count enable from the divider stage |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select code |
| wr_data_i | input | CNT_W | Write data |
| pwm_o | output | 1 | Pulse-width output |
| irq_o | output | 1 | One-cycle zero-count interrupt pulse |
| cnt_o | output | CNT_W | Active count |
| run_o | output | 1 | Start bit (channel running) |

## Verification
Every result is one register stage away from the edge that samples the stimulus. A write appears in the buffers or control bits at that edge. It reaches the counter one edge later, through a manual update or a zero event. The interrupt pulse and the halt of a one-shot run appear in the cycle after the zero tick. `pwm_o` follows the active registers combinationally, in that same cycle. The bench drives inputs on the falling edge and advances its reference model on the rising edge from the values in force before that edge. It compares every output 1 ns after each rising edge, so each expected value is taken in exactly the cycle in which the design's registers change.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef struct packed {
      logic inv;
      logic arl;
      logic mupd;
      logic start;
   } tmr_ctrl_t;

   typedef enum logic [1:0] {
      SEL_PERIOD  = 2'd0,
      SEL_COMPARE = 2'd1,
      SEL_CONTROL = 2'd2,
      SEL_SPARE   = 2'd3
   } tmr_sel_e;

   localparam int CTRL_W = $bits(tmr_ctrl_t);
endpackage

// File: rtl/tmr_buf_regs.sv
module tmr_buf_regs
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_sel_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic             halt_i,
   output logic [CNT_W-1:0] period_buf_o,
   output logic [CNT_W-1:0] compare_buf_o,
   output tmr_ctrl_t        ctrl_o
);
   tmr_sel_e  sel;
   logic      ctl_wr;

   assign sel    = tmr_sel_e'(wr_sel_i);
   assign ctl_wr = wr_en_i && (sel == SEL_CONTROL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_buf_o  <= '0;
         compare_buf_o <= '0;
         ctrl_o        <= '0;
      end else begin
         if (wr_en_i && sel == SEL_PERIOD)  period_buf_o  <= wr_data_i;
         if (wr_en_i && sel == SEL_COMPARE) compare_buf_o <= wr_data_i;
         if (ctl_wr)
            ctrl_o <= tmr_ctrl_t'(wr_data_i[CTRL_W-1:0]);
         else if (halt_i)
            ctrl_o.start <= 1'b0;
      end
   end

   // one-shot run ends by clearing start unless software writes control
   assert_halt_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_i && !ctl_wr) |=> !ctrl_o.start);

   // the spare select code leaves every register untouched
   assert_spare_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && sel == SEL_SPARE) |=> ($stable(period_buf_o) && $stable(compare_buf_o)));
endmodule

// File: rtl/tmr_down_ctr.sv
module tmr_down_ctr
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  tmr_ctrl_t        ctrl_i,
   input  logic [CNT_W-1:0] period_buf_i,
   input  logic [CNT_W-1:0] compare_buf_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cmp_o,
   output logic             irq_o,
   output logic             halt_o
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic step;
   logic at_zero;
   logic zero_evt;

   assign step     = ctrl_i.start && tick_i && !ctrl_i.mupd;
   assign at_zero  = (cnt_o == ZERO);
   assign zero_evt = step && at_zero;
   assign halt_o   = zero_evt && !ctrl_i.arl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= ZERO;
         cmp_o <= ZERO;
         irq_o <= 1'b0;
      end else begin
         irq_o <= zero_evt;
         if (ctrl_i.mupd || (zero_evt && ctrl_i.arl)) begin
            cnt_o <= period_buf_i;
            cmp_o <= compare_buf_i;
         end else if (step && !at_zero) begin
            cnt_o <= cnt_o - ONE;
         end
      end
   end

   assert_tick_decrements_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_i.start && tick_i && !ctrl_i.mupd && cnt_o != ZERO) |=> (cnt_o == $past(cnt_o) - ONE));

   assert_irq_follows_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(ctrl_i.start && tick_i && !ctrl_i.mupd && cnt_o == ZERO));

   assert_manual_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_i.mupd |=> (cnt_o == $past(period_buf_i) && cmp_o == $past(compare_buf_i)));

   assert_stopped_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_i.start && !ctrl_i.mupd) |=> $stable(cnt_o));

   assert_cmp_only_on_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_i.mupd && !tick_i) |=> $stable(cmp_o));
endmodule

// File: rtl/tmr_pwm_level.sv
module tmr_pwm_level #(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic             inv_i,
   output logic             level_o
);
   logic past_match;

   // high phase once the count has come down to the compare value
   assign past_match = (cnt_i <= cmp_i);
   assign level_o    = past_match ^ inv_i;

   always_comb begin
      assert_polarity_R9: assert (level_o == ((cnt_i > cmp_i) ? inv_i : !inv_i));
   end
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_sel_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic             pwm_o,
   output logic             irq_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             run_o
);
   if (CNT_W < CTRL_W || CNT_W > 32) begin : g_bad_width
      $error("pwm_timer_chan: CNT_W must lie between the control width and 32");
   end

   logic [CNT_W-1:0] period_buf;
   logic [CNT_W-1:0] compare_buf;
   logic [CNT_W-1:0] cmp_act;
   tmr_ctrl_t        ctrl;
   logic             halt;
   logic             level;

   tmr_buf_regs #(.CNT_W(CNT_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en_i      (wr_en_i),
      .wr_sel_i     (wr_sel_i),
      .wr_data_i    (wr_data_i),
      .halt_i       (halt),
      .period_buf_o (period_buf),
      .compare_buf_o(compare_buf),
      .ctrl_o       (ctrl)
   );

   tmr_down_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick_i),
      .ctrl_i       (ctrl),
      .period_buf_i (period_buf),
      .compare_buf_i(compare_buf),
      .cnt_o        (cnt_o),
      .cmp_o        (cmp_act),
      .irq_o        (irq_o),
      .halt_o       (halt)
   );

   tmr_pwm_level #(.CNT_W(CNT_W)) u_lvl (
      .cnt_i  (cnt_o),
      .cmp_i  (cmp_act),
      .inv_i  (ctrl.inv),
      .level_o(level)
   );

   if (REG_OUT) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pwm_o <= 1'b1;
         else        pwm_o <= level;
      end
   end else begin : g_out_comb
      assign pwm_o = level;
   end

   assign run_o = ctrl.start;

   // a zero interrupt never repeats on the next clock unless a new zero tick occurred
   assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !(ctrl.start && tick_i && cnt_o == '0)) |=> !irq_o);
endmodule

// File: tb/pwm_timer_chan_bench.sv
`timescale 1ns/1ps
module pwm_timer_chan_bench;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_i = 1'b0;
   logic         wr_en_i = 1'b0;
   logic [1:0]   wr_sel_i = 2'd0;
   logic [W-1:0] wr_data_i = '0;
   logic         pwm_o, irq_o, run_o;
   logic [W-1:0] cnt_o;

   always #2.5 clk = ~clk;

   pwm_timer_chan #(.CNT_W(W)) u_pwm_timer_chan (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
      .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .pwm_o(pwm_o),
      .irq_o(irq_o), .cnt_o(cnt_o), .run_o(run_o)
   );

   int    vectors = 0;
   int    misses  = 0;
   int    tick_div = 1;
   int    tick_phase = 0;
   int    irq_seen = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // behavioural reference state
   int m_cnt = 0, m_cmp = 0, m_pb = 0, m_cb = 0;
   bit m_start = 0, m_mupd = 0, m_arl = 0, m_inv = 0, m_irq = 0;

   always @(posedge clk) begin
      bit halt;
      if (!rst_n) begin
         m_cnt = 0; m_cmp = 0; m_pb = 0; m_cb = 0;
         m_start = 0; m_mupd = 0; m_arl = 0; m_inv = 0; m_irq = 0;
      end else begin
         halt = 1'b0;
         m_irq = 1'b0;
         if (m_mupd) begin
            m_cnt = m_pb; m_cmp = m_cb;
         end else if (m_start && tick_i) begin
            if (m_cnt == 0) begin
               m_irq = 1'b1;
               if (m_arl) begin m_cnt = m_pb; m_cmp = m_cb; end
               else halt = 1'b1;
            end else begin
               m_cnt = m_cnt - 1;
            end
         end
         if (wr_en_i && wr_sel_i == 2'd0) m_pb = int'(wr_data_i);
         if (wr_en_i && wr_sel_i == 2'd1) m_cb = int'(wr_data_i);
         if (wr_en_i && wr_sel_i == 2'd2) begin
            m_start = wr_data_i[0]; m_mupd = wr_data_i[1];
            m_arl = wr_data_i[2]; m_inv = wr_data_i[3];
         end else if (halt) begin
            m_start = 1'b0;
         end
      end
   end

   task automatic check(input string req, input string what, input int got, input int exp);
      vectors++;
      if (got != exp) begin
         misses++;
         $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
      end
   endtask

   // compare every output shortly after each rising edge
   always @(posedge clk) begin
      #1;
      if (!done) begin
         check(cur_req, "cnt_o", int'(cnt_o), m_cnt);
         check(cur_req, "run_o", int'(run_o), int'(m_start));
         check((m_irq ? "R3" : cur_req), "irq_o", int'(irq_o), int'(m_irq));
         check("R9", "pwm_o", int'(pwm_o), int'((m_cnt <= m_cmp) ^ m_inv));
         if (irq_o) irq_seen++;
      end
   end

   // divider-stage stand-in: one tick every tick_div cycles
   always @(negedge clk) begin
      tick_phase = (tick_phase + 1) % tick_div;
      tick_i <= (tick_phase == 0);
   end

   task automatic wr(input logic [1:0] sel, input int data);
      @(negedge clk);
      wr_en_i <= 1'b1; wr_sel_i <= sel; wr_data_i <= W'(data);
      @(negedge clk);
      wr_en_i <= 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   endtask

   initial begin
      cur_req = "R1";
      idle(4);
      check("R1", "reset cnt_o", int'(cnt_o), 0);
      check("R1", "reset pwm_o", int'(pwm_o), 1);
      rst_n <= 1'b1;
      idle(2);
      // load through manual update, then run with auto-reload (R4, R5, R2)
      cur_req = "R4";
      wr(2'd0, 5); wr(2'd1, 2);
      wr(2'd2, 4'b0110);
      cur_req = "R5";
      wr(2'd2, 4'b0101);
      idle(30);
      // buffer writes during a run wait for the next zero (R8)
      cur_req = "R8";
      wr(2'd0, 3); wr(2'd1, 1);
      idle(20);
      // sparse ticks (R2)
      cur_req = "R2";
      tick_div = 3;
      idle(30);
      tick_div = 1;
      // inverted output (R9)
      cur_req = "R9";
      wr(2'd2, 4'b1101);
      idle(20);
      // forced stop keeps the count (R7)
      cur_req = "R7";
      wr(2'd2, 4'b0100);
      idle(10);
      wr(2'd2, 4'b0101);
      idle(7);
      // one-shot run parks at zero (R6)
      cur_req = "R6";
      wr(2'd0, 4); wr(2'd1, 9);
      wr(2'd2, 4'b0010);
      wr(2'd2, 4'b0001);
      idle(15);
      check("R6", "one-shot run_o", int'(run_o), 0);
      check("R6", "one-shot cnt_o", int'(cnt_o), 0);
      // manual update held with start: no counting (R4)
      cur_req = "R4";
      wr(2'd0, 7);
      wr(2'd2, 4'b0111);
      idle(5);
      wr(2'd2, 4'b0101);
      idle(12);
      // spare select code ignored (R10)
      cur_req = "R10";
      wr(2'd3, 16'hFFFF);
      idle(25);
      check("R3", "interrupts observed", int'(irq_seen > 0), 1);
      finish_run();
   end

   initial begin
      #200000;
      if (!done) begin
         misses++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end
endmodule